// File: doc/BRIEF.md
# Prioritised Interrupt Request Unit

This block gathers a vector of level-sensitive interrupt lines and turns them into a single outstanding interrupt request, given as an index and a valid level. The lower half of the index space belongs to PCI slot lines and the upper half to on-board I/O lines. Each PCI mapping register gates a group of four neighbouring PCI lines. Each I/O line has a mapping register of its own. Bit 31 of every mapping register is the enable.

Software reaches the block through a simple register port. It can read the mapping registers and flip their enables. It acknowledges the current request by writing to clear registers. Once a request is taken it is held, and offered again, until a matching clear or a disabling mapping write removes it. The block then rescans its pending lines in the same clock. The scan prefers the lowest index, so every PCI line wins over every I/O line.

Top module: `irq_req_unit`

## Requirements
- R1: Each input is registered into a pending bit on every clock. When a line rises on an enabled group and no request is held, `req_valid` goes high two clocks after the rise and `req_idx` carries that line's index.
- R2: PCI mapping register g (0..7) gates lines 4g..4g+3. I/O mapping register k (0..31) gates line 32+k. A pending line whose enable is 0 never becomes a request.
- R3: A mapping write changes only bit 31. A read returns the enable in bit 31 and fixed low bits: (0x1F<<6)|(g<<2) for PCI entry g, and 0x7E0+k for I/O entry k.
- R4: Every access uses byte address bit 2 set. The windows are: PCI mapping at 0xC00+8g, I/O mapping at 0x1000+8k, PCI clear at 0x1400+32s (slot s = address bits 7:5), and I/O clear at 0x1800+8k (line 32+k). Reads of clear addresses return 0.
- R5: With address bit 2 clear, a read returns 0 and a write changes nothing.
- R6: With no request held, the scan picks the lowest-index line that is both pending and enabled. Lines 0..31 therefore come before lines 32..63.
- R7: A held request keeps its index while no register write takes place. This holds even if its line falls or a lower-index line rises.
- R8: A PCI clear drops the request only when the request index is below 32 and the index divided by 4 equals the addressed slot. The rescan updates the request on that same clock edge.
- R9: An I/O clear drops the request only on an exact index match, then rescans on that edge. A line that is still pending is picked again.
- R10: A mapping write with bit 31 at 0 that covers the line of the held request withdraws the request and rescans on that edge, using the new enables.
- R11: Reset clears all enables, all pending bits and the held request. The fixed low mapping bits still read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Interrupt lines, PCI 0..31 then I/O 32..63 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data (bit 31 used) |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_valid | output | 1 | A request is outstanding |
| req_idx | output | 6 | Index of the outstanding request |

## Verification
The bench builds the unit with its default geometry: 32 PCI lines in groups of four plus 32 individually enabled I/O lines. This lets a single run reach shared-group effects, where one enable covers a held line and its lower neighbour, and the boundary between the last PCI group and the first I/O line. It also reaches clears that target a slot which cannot hold an I/O index. Expected requests and read values are worked out by hand from the requirements and compared on the negative clock edge after each event.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;

    localparam int PCI_LINES     = 32;
    localparam int IO_LINES      = 32;
    localparam int LINES_PER_MAP = 4;
    localparam int NUM_LINES     = PCI_LINES + IO_LINES;
    localparam int IDX_W         = $clog2(NUM_LINES);
    localparam int PCI_MAPS      = PCI_LINES / LINES_PER_MAP;
    localparam int PM_W          = $clog2(PCI_MAPS);
    localparam int IO_W          = $clog2(IO_LINES);
    localparam int ADDR_W        = 16;
    localparam int DATA_W        = 32;
    localparam int EN_BIT        = DATA_W - 1;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_PCI_MAP,
        ACC_IO_MAP,
        ACC_PCI_CLR,
        ACC_IO_CLR
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e         kind;
        logic [IO_W-1:0]   entry;
    } acc_t;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
    } req_t;

    // Address window decode; only upper-word slots (bit 2 set) are live.
    function automatic acc_t decode_acc(input logic [ADDR_W-1:0] a);
        acc_t r;
        r.kind  = ACC_NONE;
        r.entry = '0;
        if (a[2]) begin
            if (a[15:6] == 10'h030) begin
                r.kind  = ACC_PCI_MAP;
                r.entry = IO_W'(a[5:3]);
            end else if (a[15:8] == 8'h10) begin
                r.kind  = ACC_IO_MAP;
                r.entry = a[7:3];
            end else if (a[15:8] == 8'h14) begin
                r.kind  = ACC_PCI_CLR;
                r.entry = IO_W'(a[7:5]);
            end else if (a[15:8] == 8'h18) begin
                r.kind  = ACC_IO_CLR;
                r.entry = a[7:3];
            end
        end
        return r;
    endfunction

    function automatic logic [DATA_W-2:0] pci_low(input int g);
        return (DATA_W-1)'((32'h1F << 6) | (g << 2));
    endfunction

    function automatic logic [DATA_W-2:0] io_low(input int k);
        return (DATA_W-1)'(32'h7E0 + k);
    endfunction

endpackage

// File: rtl/irq_map_regs.sv
module irq_map_regs
    import irq_req_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  acc_t                  acc,
    input  logic                  wen_bit,
    output logic [NUM_LINES-1:0]  line_en_nx,
    output logic [DATA_W-1:0]     rdata
);

    logic [PCI_MAPS-1:0] pci_en_q, pci_en_d;
    logic [IO_LINES-1:0] io_en_q,  io_en_d;

    always_comb begin
        pci_en_d = pci_en_q;
        io_en_d  = io_en_q;
        if (wr && acc.kind == ACC_PCI_MAP)
            pci_en_d[acc.entry[PM_W-1:0]] = wen_bit;
        if (wr && acc.kind == ACC_IO_MAP)
            io_en_d[acc.entry] = wen_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pci_en_q <= '0;
            io_en_q  <= '0;
        end else begin
            pci_en_q <= pci_en_d;
            io_en_q  <= io_en_d;
        end
    end

    // Per-line enable as it stands after this edge
    for (genvar g = 0; g < PCI_LINES; g++) begin : g_pci_en
        assign line_en_nx[g] = pci_en_d[g / LINES_PER_MAP];
    end
    for (genvar k = 0; k < IO_LINES; k++) begin : g_io_en
        assign line_en_nx[PCI_LINES + k] = io_en_d[k];
    end

    always_comb begin
        rdata = '0;
        case (acc.kind)
            ACC_PCI_MAP: rdata = {pci_en_q[acc.entry[PM_W-1:0]],
                                  pci_low(int'(acc.entry[PM_W-1:0]))};
            ACC_IO_MAP:  rdata = {io_en_q[acc.entry], io_low(int'(acc.entry))};
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_req_pkg::*;
(
    input  logic [NUM_LINES-1:0] cand,
    output req_t                 pick
);

    // Lowest set index wins
    always_comb begin
        pick = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick.valid = 1'b1;
                pick.idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_req_hold.sv
module irq_req_hold
    import irq_req_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  acc_t acc,
    input  logic wen_bit,
    input  req_t pick,
    output req_t cur
);

    logic in_pci, grp_hit, line_hit;
    logic clr_pci, clr_io, withdraw, drop;

    assign in_pci   = int'(cur.idx) < PCI_LINES;
    assign grp_hit  = in_pci && (int'(cur.idx) / LINES_PER_MAP == int'(acc.entry));
    assign line_hit = !in_pci && (int'(cur.idx) == PCI_LINES + int'(acc.entry));

    assign clr_pci  = wr && cur.valid && acc.kind == ACC_PCI_CLR && grp_hit;
    assign clr_io   = wr && cur.valid && acc.kind == ACC_IO_CLR  && line_hit;
    assign withdraw = wr && cur.valid && !wen_bit &&
                      ((acc.kind == ACC_PCI_MAP && grp_hit) ||
                       (acc.kind == ACC_IO_MAP  && line_hit));
    assign drop     = clr_pci || clr_io || withdraw;

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (!cur.valid || drop)
            cur <= pick;
    end

endmodule

// File: rtl/irq_req_unit.sv
module irq_req_unit
    import irq_req_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LINES-1:0]  irq_in,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  req_valid,
    output logic [IDX_W-1:0]      req_idx
);

    acc_t                 acc;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] line_en_nx;
    req_t                 pick, cur;
    logic                 wen_bit;
    logic                 unused_wdata;

    assign acc          = decode_acc(reg_addr);
    assign wen_bit      = reg_wdata[EN_BIT];
    assign unused_wdata = ^reg_wdata[EN_BIT-1:0];

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= irq_in;
    end

    irq_map_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .acc        (acc),
        .wen_bit    (wen_bit),
        .line_en_nx (line_en_nx),
        .rdata      (reg_rdata)
    );

    irq_pick u_pick (
        .cand (pend_q & line_en_nx),
        .pick (pick)
    );

    irq_req_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .acc     (acc),
        .wen_bit (wen_bit),
        .pick    (pick),
        .cur     (cur)
    );

    assign req_valid = cur.valid;
    assign req_idx   = cur.idx;

endmodule

// File: rtl/irq_req_unit_chk.sv
module irq_req_unit_chk
    import irq_req_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic                 req_valid,
    input logic [IDX_W-1:0]     req_idx,
    input logic [NUM_LINES-1:0] pend_q
);

    logic [NUM_LINES-1:0] pend_d;

    always_ff @(posedge clk) begin
        if (rst) pend_d <= '0;
        else     pend_d <= pend_q;
    end

    // A fresh request names a line that was pending at the scan
    assert_fresh_pending_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> pend_d[req_idx]);

    // Lower-word slots read as zero
    assert_low_word_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !reg_addr[2] |-> reg_rdata == '0);

    // Held request is stable without register traffic
    assert_request_held_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !reg_wr) |=> (req_valid && $stable(req_idx)));

    // No request right after reset
    assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !req_valid);

endmodule

bind irq_req_unit irq_req_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .req_valid (req_valid),
    .req_idx   (req_idx),
    .pend_q    (pend_q)
);

// File: tb/irq_req_unit_test.sv
`timescale 1ns/100ps
module irq_req_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic [5:0]  req_idx;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_req_unit uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_idx(req_idx)
    );

    typedef struct {
        bit          is_read;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    // Monitor: compares one expectation per negative edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            bit bad;
            it = sb.pop_front();
            n_run++;
            if (it.is_read) begin
                act = reg_rdata;
                bad = (act !== it.exp);
            end else begin
                act = {25'd0, req_valid, req_idx};
                bad = (req_valid !== it.exp[6]) ||
                      (it.exp[6] && req_idx !== it.exp[5:0]);
            end
            if (bad) begin
                n_fail++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic push_req(bit v, int idx, string tag);
        item_t it;
        it.is_read = 0;
        it.exp = {25'd0, v, 6'(idx)};
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle_chk(bit v, int idx, string tag);
        push_req(v, idx, tag);
        tick();
    endtask

    task automatic wr_chk(logic [15:0] a, logic [31:0] d, bit v, int idx, string tag);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        push_req(v, idx, tag);
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(logic [15:0] a, logic [31:0] e, string tag);
        item_t it;
        reg_addr = a;
        it.is_read = 1; it.exp = e; it.tag = tag;
        sb.push_back(it);
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        idle_chk(0, 0, "R11 reset no request");
        rd_chk(16'h0C1C, 32'h0000_07CC, "R11 R3 pci map 3 reset");
        rd_chk(16'h102C, 32'h0000_07E5, "R11 R3 io map 5 reset");

        // disabled group holds back a pending line
        irq_in[5] = 1'b1;
        idle_chk(0, 0, "R2 disabled");
        idle_chk(0, 0, "R2 disabled");
        idle_chk(0, 0, "R2 disabled");
        wr_chk(16'h0C0C, 32'h8000_0123, 1, 5, "R2 enable group 1");
        rd_chk(16'h0C0C, 32'h8000_07C4, "R3 only bit31 written");

        // held request ignores lower line and its own line falling
        irq_in[4] = 1'b1;
        idle_chk(1, 5, "R7 lower line rises");
        idle_chk(1, 5, "R7 lower line rises");
        irq_in[5] = 1'b0;
        idle_chk(1, 5, "R7 own line falls");
        idle_chk(1, 5, "R7 own line falls");

        wr_chk(16'h1404, 32'h0, 1, 5, "R8 wrong slot");
        wr_chk(16'h1424, 32'h0, 1, 4, "R8 slot match rescan");

        wr_chk(16'h101C, 32'h8000_0000, 1, 4, "R2 io enable 35");
        irq_in[35] = 1'b1;
        idle_chk(1, 4, "R7 held");
        idle_chk(1, 4, "R7 held");
        wr_chk(16'h0C0C, 32'h0, 1, 35, "R10 withdraw group 1");
        rd_chk(16'h0C0C, 32'h0000_07C4, "R3 disabled readback");

        wr_chk(16'h1824, 32'h0, 1, 35, "R9 io clear mismatch");
        wr_chk(16'h181C, 32'h0, 1, 35, "R9 io clear level repick");
        irq_in[35] = 1'b0;
        idle_chk(1, 35, "R7 held");
        wr_chk(16'h181C, 32'h0, 0, 0, "R9 io clear empties");

        // priority across ranges and two-cycle latency
        wr_chk(16'h0C3C, 32'h8000_0000, 0, 0, "R2 enable group 7");
        wr_chk(16'h1004, 32'h8000_0000, 0, 0, "R2 enable io 32");
        irq_in[30] = 1'b1; irq_in[32] = 1'b1;
        idle_chk(0, 0, "R1 one clock after rise");
        idle_chk(1, 30, "R1 R6 two clocks, pci first");
        wr_chk(16'h14E4, 32'h0, 1, 30, "R8 clear level repick");
        irq_in[30] = 1'b0;
        idle_chk(1, 30, "R7 held");
        wr_chk(16'h14E4, 32'h0, 1, 32, "R6 R8 rescan to io");
        wr_chk(16'h1404, 32'h0, 1, 32, "R8 pci clear vs io request");

        // lower word slot
        rd_chk(16'h0C38, 32'h0, "R5 lower word read");
        wr_chk(16'h0C38, 32'h0, 1, 32, "R5 lower word write");
        rd_chk(16'h0C3C, 32'h8000_07DC, "R5 enable kept");
        rd_chk(16'h1004, 32'h8000_07E0, "R4 io map 0");
        rd_chk(16'h10FC, 32'h0000_07FF, "R4 io map 31");
        rd_chk(16'h1424, 32'h0, "R4 clear reads zero");

        // reset mid-run
        rst = 1'b1;
        tick();
        rst = 1'b0;
        rd_chk(16'h1004, 32'h0000_07E0, "R11 enable cleared");
        idle_chk(0, 0, "R11 request cleared");
        idle_chk(0, 0, "R11 request cleared");
        tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule